// File: doc/BRIEF.md
# PLL Setting Search Engine

This block finds a frequency synthesizer setting for a requested output rate. It takes a reference rate and a target rate. It then walks a fixed grid of settings: a feedback multiplier, a first-stage divider and a power-of-two second-stage divider. For each setting it forms the rate the synthesizer would produce. It keeps the best rate that does not exceed the target.

A single `start` pulse launches a search. Several cycles later a one-cycle `done` pulse marks the result outputs as valid. The result holds the chosen fields, the achieved rate, a flag that says whether the match is exact, and a flag for the case where no setting fits. The fields are also packed into one control word, ready to load into a synthesizer configuration register.

An iterative divider computes reference / (div1 × 2^div2) once per divider pair. After that, an accumulator steps through the multipliers with one addition per cycle, so no multiplier array and no per-candidate division is needed.

Top module: `pll_srch_top`

## Requirements
- R1: The sweep visits div1 from 5 down to 3 in the outer loop, then div2 from 3 down to 0, then mul from 3 up to 1023 in the inner loop. Every reported setting lies in those ranges.
- R2: The reported rate equals floor(reference × mul / (div1 × 2^div2)) for the reported fields. The product is evaluated without overflow for any 32-bit reference.
- R3: A setting whose rate exceeds the target is never chosen, so the reported rate is at most the target.
- R4: The first setting with a rate equal to the target ends the search at once. It is reported with `res_exact` = 1, and the search does not visit any later setting.
- R5: When no exact match exists, the setting with the smallest shortfall wins. On equal shortfall the one visited first in sweep order is kept, and `res_exact` = 0.
- R6: `res_ctrl` packs div2 in bits 14:13, div1 in bits 12:10 and mul in bits 9:0.
- R7: When every setting exceeds the target, `res_nosol` = 1 and mul, div1, div2, rate, exact and the control word are all 0.
- R8: A `start` pulse while a search is running has no effect: the result reflects the request that launched the running search.
- R9: `done` is high for exactly one cycle per search. The result outputs are valid in that cycle and hold until the next search completes.
- R10: After reset, `done`, every result field and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a search (ignored while busy) |
| ref_rate | input | 32 | Reference rate, unsigned |
| tgt_rate | input | 32 | Requested rate, unsigned |
| done | output | 1 | One-cycle completion strobe |
| res_mul | output | 10 | Chosen multiplier |
| res_div1 | output | 3 | Chosen first-stage divider |
| res_div2 | output | 2 | Chosen power-of-two exponent |
| res_rate | output | 32 | Rate of the chosen setting |
| res_exact | output | 1 | Chosen rate equals the target |
| res_nosol | output | 1 | No setting at or below the target |
| res_ctrl | output | 15 | Packed control word |

## Verification
The hardest behaviour to reach from the ports is the tie rule. Two settings with different divider pairs must give the same shortfall, and only the earlier one may win. The bench does not hand-pick such ties. Instead it compares every field against a brute-force sweep over the whole grid for a set of reference and target pairs whose ratios allow many equal-rate settings. The other hard case is a second `start` that arrives mid-sweep. The bench raises it a fixed number of cycles after launch, while the divider is still busy, and then expects the result of the first request.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DIVS,
    S_DIVW,
    S_STEP,
    S_NEXT,
    S_DONE
  } srch_state_e;

endpackage

// File: rtl/pll_srch_div.sv
// Restoring serial divider: one quotient bit per cycle, MSB first.
module pll_srch_div #(
  parameter int N_W = 32,
  parameter int D_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic [N_W-1:0] quo,
  output logic [D_W-1:0] rem,
  output logic           done
);
  localparam int C_W = $clog2(N_W + 1);

  logic [N_W-1:0] quo_q, quo_n;
  logic [D_W-1:0] rem_q, rem_n;
  logic [C_W-1:0] cnt_q, cnt_n;
  logic           busy_q, busy_n;
  logic           done_q, done_n;
  logic [D_W:0]   trial;
  logic [D_W:0]   diff;
  logic           ge;

  always_comb begin
    trial  = {rem_q, quo_q[N_W-1]};
    ge     = trial >= {1'b0, divisor};
    diff   = trial - {1'b0, divisor};
    quo_n  = quo_q;
    rem_n  = rem_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (go) begin
      quo_n  = dividend;
      rem_n  = '0;
      cnt_n  = C_W'(N_W);
      busy_n = 1'b1;
    end else if (busy_q) begin
      quo_n = {quo_q[N_W-2:0], ge};
      rem_n = ge ? diff[D_W-1:0] : trial[D_W-1:0];
      cnt_n = cnt_q - 1'b1;
      if (cnt_q == C_W'(1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      quo_q  <= quo_n;
      rem_q  <= rem_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  assign quo  = quo_q;
  assign rem  = rem_q;
  assign done = done_q;

  // R2: remainder below divisor once the quotient is ready
  assert_rem_below_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q < divisor));
  // R2: divisor held steady while bits are being produced
  assert_divisor_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_n) |=> $stable(divisor));
endmodule

// File: rtl/pll_srch_acc.sv
// Running floor(ref*mul/dvs): per step adds quotient and remainder of ref/dvs.
module pll_srch_acc #(
  parameter int REF_W = 32,
  parameter int Q_W   = 42,
  parameter int R_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [REF_W-1:0] qd,
  input  logic [R_W-1:0]   rd,
  input  logic [R_W-1:0]   dvs,
  output logic [Q_W-1:0]   q
);
  logic [Q_W-1:0] q_q, q_n;
  logic [R_W-1:0] r_q, r_n;
  logic [R_W:0]   rsum;
  logic [R_W:0]   rwrap;
  logic           wrap;

  always_comb begin
    rsum  = {1'b0, r_q} + {1'b0, rd};
    wrap  = rsum >= {1'b0, dvs};
    rwrap = rsum - {1'b0, dvs};
    q_n   = q_q;
    r_n   = r_q;
    if (load) begin
      q_n = '0;
      r_n = '0;
    end else if (step) begin
      q_n = q_q + Q_W'(qd) + Q_W'(wrap);
      r_n = wrap ? rwrap[R_W-1:0] : rsum[R_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
      r_q <= '0;
    end else begin
      q_q <= q_n;
      r_q <= r_n;
    end
  end

  assign q = q_q;

  // R2: fractional part stays a proper remainder of the current divisor
  assert_frac_proper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (r_q < dvs));
  // R2: candidate never decreases while stepping
  assert_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (q_q >= $past(q_q)));
endmodule

// File: rtl/pll_srch_top.sv
module pll_srch_top
  import pll_srch_pkg::*;
#(
  parameter int REF_W   = 32,
  parameter int MUL_W   = 10,
  parameter int MUL_MIN = 3,
  parameter int MUL_MAX = 1023,
  parameter int D1_HI   = 5,
  parameter int D1_LO   = 3,
  parameter int D2_HI   = 3,
  localparam int D1_W   = $clog2(D1_HI + 1),
  localparam int D2_W   = $clog2(D2_HI + 1),
  localparam int CW_W   = D2_W + D1_W + MUL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REF_W-1:0] ref_rate,
  input  logic [REF_W-1:0] tgt_rate,
  output logic             done,
  output logic [MUL_W-1:0] res_mul,
  output logic [D1_W-1:0]  res_div1,
  output logic [D2_W-1:0]  res_div2,
  output logic [REF_W-1:0] res_rate,
  output logic             res_exact,
  output logic             res_nosol,
  output logic [CW_W-1:0]  res_ctrl
);
  localparam int PROD_W = REF_W + MUL_W;
  localparam int DVS_W  = $clog2(D1_HI * (1 << D2_HI) + 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  srch_state_e      state_q, state_n;
  logic [REF_W-1:0] ref_q, ref_n, tgt_q, tgt_n;
  logic [D1_W-1:0]  d1_q, d1_n;
  logic [D2_W-1:0]  d2_q, d2_n;
  logic [MUL_W-1:0] mul_q, mul_n;
  logic             found_q, found_n, exact_q, exact_n;
  logic [REF_W-1:0] berr_q, berr_n, brate_q, brate_n;
  logic [MUL_W-1:0] bmul_q, bmul_n;
  logic [D1_W-1:0]  bd1_q, bd1_n;
  logic [D2_W-1:0]  bd2_q, bd2_n;
  logic             res_en, done_n;

  logic [DVS_W-1:0] dvs;
  logic             div_go, div_done, acc_step;
  logic [REF_W-1:0] div_quo;
  logic [DVS_W-1:0] div_rem;
  logic [PROD_W-1:0] cand;
  logic             fits, record;
  logic [REF_W-1:0] err;

  assign dvs    = DVS_W'(d1_q) << d2_q;
  assign div_go = (state_q == S_DIVS);

  pll_srch_div #(.N_W(REF_W), .D_W(DVS_W)) div_i (
    .clk(clk), .rst_n(rst_l), .go(div_go), .dividend(ref_q), .divisor(dvs),
    .quo(div_quo), .rem(div_rem), .done(div_done));

  pll_srch_acc #(.REF_W(REF_W), .Q_W(PROD_W), .R_W(DVS_W)) acc_i (
    .clk(clk), .rst_n(rst_l), .load(div_done), .step(acc_step),
    .qd(div_quo), .rd(div_rem), .dvs(dvs), .q(cand));

  assign fits = cand <= PROD_W'(tgt_q);
  assign err  = tgt_q - cand[REF_W-1:0];

  always_comb begin
    state_n  = state_q;
    ref_n    = ref_q;    tgt_n   = tgt_q;
    d1_n     = d1_q;     d2_n    = d2_q;    mul_n  = mul_q;
    found_n  = found_q;  exact_n = exact_q; berr_n = berr_q;
    brate_n  = brate_q;  bmul_n  = bmul_q;  bd1_n  = bd1_q;  bd2_n = bd2_q;
    acc_step = 1'b0;
    record   = 1'b0;
    res_en   = 1'b0;
    done_n   = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        ref_n   = ref_rate;  tgt_n  = tgt_rate;
        d1_n    = D1_W'(D1_HI); d2_n = D2_W'(D2_HI);
        found_n = 1'b0;      exact_n = 1'b0;  berr_n = '0;
        brate_n = '0;        bmul_n  = '0;    bd1_n  = '0;  bd2_n = '0;
        state_n = S_DIVS;
      end
      S_DIVS: state_n = S_DIVW;
      S_DIVW: if (div_done) begin
        mul_n   = '0;
        state_n = S_STEP;
      end
      S_STEP: begin
        if (mul_q < MUL_W'(MUL_MIN)) begin
          acc_step = 1'b1;
          mul_n    = mul_q + 1'b1;
        end else if (fits && err == '0) begin
          record  = 1'b1;
          exact_n = 1'b1;
          state_n = S_DONE;
        end else begin
          record = fits && (!found_q || err < berr_q);
          if (!fits || mul_q == MUL_W'(MUL_MAX)) begin
            state_n = S_NEXT;
          end else begin
            acc_step = 1'b1;
            mul_n    = mul_q + 1'b1;
          end
        end
      end
      S_NEXT: begin
        if (d2_q != '0) begin
          d2_n    = d2_q - 1'b1;
          state_n = S_DIVS;
        end else if (d1_q != D1_W'(D1_LO)) begin
          d1_n    = d1_q - 1'b1;
          d2_n    = D2_W'(D2_HI);
          state_n = S_DIVS;
        end else begin
          state_n = S_DONE;
        end
      end
      S_DONE: begin
        res_en  = 1'b1;
        done_n  = 1'b1;
        state_n = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
    if (record) begin
      found_n = 1'b1;
      berr_n  = err;
      brate_n = cand[REF_W-1:0];
      bmul_n  = mul_q;
      bd1_n   = d1_q;
      bd2_n   = d2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      state_q <= S_IDLE;
      ref_q   <= '0;  tgt_q   <= '0;
      d1_q    <= D1_W'(D1_HI);  d2_q <= D2_W'(D2_HI);
      mul_q   <= '0;
      found_q <= 1'b0; exact_q <= 1'b0;
      berr_q  <= '0;  brate_q <= '0;
      bmul_q  <= '0;  bd1_q   <= '0;  bd2_q <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_n;
      ref_q   <= ref_n;   tgt_q   <= tgt_n;
      d1_q    <= d1_n;    d2_q    <= d2_n;
      mul_q   <= mul_n;
      found_q <= found_n; exact_q <= exact_n;
      berr_q  <= berr_n;  brate_q <= brate_n;
      bmul_q  <= bmul_n;  bd1_q   <= bd1_n;  bd2_q <= bd2_n;
      done    <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      res_mul   <= '0;  res_div1 <= '0;  res_div2 <= '0;
      res_rate  <= '0;  res_exact <= 1'b0; res_nosol <= 1'b0;
    end else if (res_en) begin
      res_mul   <= bmul_q;
      res_div1  <= bd1_q;
      res_div2  <= bd2_q;
      res_rate  <= brate_q;
      res_exact <= exact_q;
      res_nosol <= !found_q;
    end
  end

  assign res_ctrl = {res_div2, res_div1, res_mul};

  // R9: completion strobe lasts one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_l)
    done |=> !done);
  // R3: chosen rate never above the request
  assert_rate_le_tgt_R3: assert property (@(posedge clk) disable iff (!rst_l)
    (done && !res_nosol) |-> (res_rate <= tgt_q));
  // R7: empty result is all zero
  assert_nosol_zero_R7: assert property (@(posedge clk) disable iff (!rst_l)
    (done && res_nosol) |-> (res_mul == '0 && res_rate == '0 && !res_exact));
  // R1: reported setting lies inside the swept grid
  assert_grid_range_R1: assert property (@(posedge clk) disable iff (!rst_l)
    (done && !res_nosol) |-> (res_div1 >= D1_W'(D1_LO) && res_div1 <= D1_W'(D1_HI)
                              && res_mul >= MUL_W'(MUL_MIN)));
  // R8: latched request stays put while a search runs
  assert_request_held_R8: assert property (@(posedge clk) disable iff (!rst_l)
    (state_q != S_IDLE) |=> ($stable(ref_q) && $stable(tgt_q)));
  // R4: exact flag implies zero shortfall
  assert_exact_match_R4: assert property (@(posedge clk) disable iff (!rst_l)
    (done && res_exact) |-> (res_rate == tgt_q));
endmodule

// File: tb/pll_srch_top_tb_top.sv
module pll_srch_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] ref_rate, tgt_rate;
  logic        done;
  logic [9:0]  res_mul;
  logic [2:0]  res_div1;
  logic [1:0]  res_div2;
  logic [31:0] res_rate;
  logic        res_exact, res_nosol;
  logic [14:0] res_ctrl;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pll_srch_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_rate(ref_rate), .tgt_rate(tgt_rate),
    .done(done), .res_mul(res_mul), .res_div1(res_div1), .res_div2(res_div2),
    .res_rate(res_rate), .res_exact(res_exact), .res_nosol(res_nosol), .res_ctrl(res_ctrl));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // brute-force sweep of the requirements R1..R5, R7
  function automatic void model(input longint r, input longint t,
                                output longint m, output longint a1, output longint a2,
                                output longint rt, output bit ex, output bit ns);
    longint be;
    bit f;
    f = 0; be = 0; m = 0; a1 = 0; a2 = 0; rt = 0; ex = 0;
    for (int a = 5; a >= 3; a--)
      for (int b = 3; b >= 0; b--)
        for (int mm = 3; mm <= 1023; mm++) begin
          longint c, e;
          c = (r * mm) / (a * (1 << b));
          if (c > t) continue;
          e = t - c;
          if (e == 0) begin
            m = mm; a1 = a; a2 = b; rt = c; ex = 1; ns = 0;
            return;
          end
          if (!f || e < be) begin
            f = 1; be = e; m = mm; a1 = a; a2 = b; rt = c;
          end
        end
    ns = !f;
  endfunction

  task automatic launch(input logic [31:0] r, input logic [31:0] t);
    @(negedge clk);
    start = 1'b1; ref_rate = r; tgt_rate = t;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic compare(input string tag, input logic [31:0] r, input logic [31:0] t);
    longint m, a1, a2, rt;
    bit ex, ns;
    model(r, t, m, a1, a2, rt, ex, ns);
    chk({tag, " R1 R5 mul"}, res_mul, m);
    chk({tag, " R1 div1"}, res_div1, a1);
    chk({tag, " R1 div2"}, res_div2, a2);
    chk({tag, " R2 rate"}, res_rate, rt);
    chk({tag, " R4 exact"}, res_exact, ex);
    chk({tag, " R7 nosol"}, res_nosol, ns);
    chk({tag, " R6 ctrl"}, res_ctrl, (a2 << 13) | (a1 << 10) | m);
    if (!ns) chk({tag, " R3 rate<=target"}, (res_rate <= t), 1);
    if (!ns) chk({tag, " R2 floor formula"}, res_rate,
                 (longint'(r) * res_mul) / (res_div1 * (1 << res_div2)));
  endtask

  task automatic run_case(input string tag, input logic [31:0] r, input logic [31:0] t);
    int cyc;
    launch(r, t);
    wait_done(cyc);
    chk({tag, " R9 done seen"}, done, 1);
    compare(tag, r, t);
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, done, 0);
    chk({tag, " R9 result held"}, res_ctrl, (longint'(res_div2) << 13) | (res_div1 << 10) | res_mul);
  endtask

  task automatic test_reset();
    chk("R10 done", done, 0);
    chk("R10 mul", res_mul, 0);
    chk("R10 rate", res_rate, 0);
    chk("R10 ctrl", res_ctrl, 0);
    chk("R10 flags", {res_exact, res_nosol}, 0);
  endtask

  task automatic test_exact_early();
    int cyc;
    launch(32'd24000000, 32'd60000000);
    wait_done(cyc);
    compare("exact", 32'd24000000, 32'd60000000);
    chk("R4 exact flag", res_exact, 1);
    chk("R4 early stop", (cyc < 300), 1);
    @(negedge clk);
  endtask

  task automatic test_nosol();
    run_case("nosol", 32'd1000000, 32'd10);
    chk("R7 nosol flag", res_nosol, 1);
    chk("R7 zero ctrl", res_ctrl, 0);
  endtask

  task automatic test_busy_start();
    int cyc;
    launch(32'd24000000, 32'd50000001);
    repeat (20) @(negedge clk);
    start = 1'b1; ref_rate = 32'd1000000; tgt_rate = 32'd10;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    compare("R8 busy start", 32'd24000000, 32'd50000001);
    @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R8 no second done", done, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; ref_rate = '0; tgt_rate = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();
    test_exact_early();
    run_case("approx", 32'd25000000, 32'd123456789);
    run_case("tie", 32'd12000000, 32'd7654321);
    run_case("tgt0", 32'd5, 32'd0);
    run_case("wide", 32'hFFFFFFFF, 32'hFFFFFFFF);
    run_case("odd", 32'd27000000, 32'd999999937);
    test_nosol();
    test_busy_start();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule